// File: doc/BRIEF.md
# Paged MDIO register access bridge

This bridge lets a management host that only speaks 16-bit clause-22 style MDIO register transactions reach a flat space of 32-bit configuration registers. The host presents parallel requests (PHY address, register number, write data, write/read flag). The bridge turns them into single-cycle accesses on a simple 32-bit register bus with address, write data, write enable, read enable and read data. Serial MDC/MDIO framing is handled elsewhere, and so is the register file behind the bus.

The register-space address is built from three sources. A page register, written through a dedicated PHY address, supplies the upper bits. The low three bits of the PHY address supply the middle bits. The register number supplies the word index. Each 32-bit word appears as two 16-bit halves. Writes go high half first and then low half. The high half waits in a staging register, so the whole word is committed in one bus cycle when the low half arrives. Reads go low half first. That read fetches the word, returns bits [15:0] and keeps bits [31:16] for the high-half read that follows.

The request side uses valid/ready handshakes. A request is taken on a cycle where `mdio_valid` and `mdio_ready` are both high. `mdio_ready` stays low while a read response is waiting or a bus read is in flight. A read response is offered on `rsp_valid` and held, with its data stable, until `rsp_ready` is seen high. Writes produce no response. The register bus returns read data one cycle after `reg_rd_en`.

Top module: `mdio_page_bridge`

## Requirements
- R1: A write to PHY address 0x18, register 0 loads wdata[8:0] into the page register. Upper data bits are dropped. A read of the same location returns the page zero-extended to 16 bits.
- R2: For data accesses at PHY addresses 0x10 to 0x17, the bus address is {page, phy[2:0], reg[4:1], 2'b00}: page in bits [17:9], PHY bits in [8:6], word index in [5:2], and bits [1:0] always zero.
- R3: A write to an odd register number (high half) causes no bus write; its data is only staged.
- R4: A write to an even register number (low half) causes exactly one single-cycle bus write of {staged high half, written low half}. The staged value stays in place, so later low-half writes reuse it.
- R5: A read of an even register number asserts reg_rd_en for exactly one cycle and returns read data bits [15:0].
- R6: A read of the odd register next to the last low-half read address returns the latched bits [31:16] and causes no bus read.
- R7: A high-half read whose word address differs from the last low-half read, or that comes with no low-half read since reset, returns 0xFFFF.
- R8: Requests to PHY addresses outside 0x10 to 0x18, and to registers other than 0 at PHY 0x18, cause no bus access and no page change. Reads of them return 0xFFFF.
- R9: While a response is waiting or a bus read is in flight, mdio_ready is low. A response is held with stable data until rsp_ready is high.
- R10: After reset the page reads as 0, the high-half latch is empty, no response is pending and mdio_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdio_valid | input | 1 | Request valid |
| mdio_ready | output | 1 | Request accepted when high together with valid |
| mdio_write | input | 1 | 1 = write request, 0 = read request |
| mdio_phy | input | 5 | PHY address |
| mdio_reg | input | 5 | Register number |
| mdio_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 16 | Read response data |
| reg_addr | output | 18 | Register bus byte address |
| reg_wdata | output | 32 | Register bus write data |
| reg_wr_en | output | 1 | Register bus write enable |
| reg_rd_en | output | 1 | Register bus read enable |
| reg_rdata | input | 32 | Register bus read data, valid one cycle after reg_rd_en |

## Verification
The bench builds the bridge with its default parameters: a 9-bit page, 16-bit halves and a 5-bit PHY address and register number. The full 18-bit address is therefore in play. Page value 0x1FF drives the top address bit, and PHY 0x17 with register 0x1E drives the highest PHY and word-index bits. These values also let the bench show that data bits above bit 8 never reach the page.

// File: rtl/mpb_pkg.sv
package mpb_pkg;
  typedef enum logic [2:0] {
    K_BAD     = 3'd0,
    K_PAGE    = 3'd1,
    K_DATA_LO = 3'd2,
    K_DATA_HI = 3'd3
  } kind_t;
endpackage

// File: rtl/mpb_decode.sv
module mpb_decode
  import mpb_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int PHY_W  = 5,
  parameter int REG_W  = 5,
  parameter logic [PHY_W-1:0] PAGE_PHY  = 5'h18,
  parameter logic [PHY_W-1:0] DATA_BASE = 5'h10,
  localparam int ADDR_W = PAGE_W + 3 + (REG_W - 1) + 2
) (
  input  logic [PHY_W-1:0]  phy,
  input  logic [REG_W-1:0]  regn,
  input  logic [PAGE_W-1:0] page,
  output kind_t             kind,
  output logic [ADDR_W-1:0] addr
);
  logic in_data;

  assign in_data = (phy[PHY_W-1:3] == DATA_BASE[PHY_W-1:3]);
  assign addr    = {page, phy[2:0], regn[REG_W-1:1], 2'b00};

  always_comb begin
    kind = K_BAD;
    if (in_data) begin
      kind = regn[0] ? K_DATA_HI : K_DATA_LO;
    end else if (phy == PAGE_PHY && regn == '0) begin
      kind = K_PAGE;
    end
  end
endmodule

// File: rtl/mpb_write_stage.sv
module mpb_write_stage
  import mpb_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_wr,
  input  kind_t             kind,
  input  logic [HALF_W-1:0] wdata,
  output logic [PAGE_W-1:0] page,
  output logic              reg_wr_en,
  output logic [WORD_W-1:0] reg_wdata
);
  logic [HALF_W-1:0] stage_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page     <= '0;
      stage_hi <= '0;
    end else if (fire_wr) begin
      if (kind == K_PAGE)    page     <= wdata[PAGE_W-1:0];
      if (kind == K_DATA_HI) stage_hi <= wdata;
    end
  end

  assign reg_wr_en = fire_wr && (kind == K_DATA_LO);
  assign reg_wdata = {stage_hi, wdata};

  // R1: the page moves only on an accepted page write
  a_r1_page_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire_wr && kind == K_PAGE) |=> $stable(page));
endmodule

// File: rtl/mpb_read_path.sv
module mpb_read_path
  import mpb_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int HALF_W = 16,
  parameter int ADDR_W = 18,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_rd,
  input  kind_t             kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] page,
  input  logic [WORD_W-1:0] reg_rdata,
  input  logic              rsp_ready,
  output logic              reg_rd_en,
  output logic              rsp_valid,
  output logic [HALF_W-1:0] rsp_data,
  output logic              busy
);
  logic              rd_pend;
  logic              hi_valid;
  logic [ADDR_W-1:0] hi_tag;
  logic [ADDR_W-1:0] pend_tag;
  logic [HALF_W-1:0] hi_latch;
  logic [HALF_W-1:0] quick_data;

  assign reg_rd_en = fire_rd && (kind == K_DATA_LO);
  assign busy      = rsp_valid || rd_pend;

  always_comb begin
    case (kind)
      K_PAGE:    quick_data = {{(HALF_W-PAGE_W){1'b0}}, page};
      K_DATA_HI: quick_data = (hi_valid && hi_tag == addr) ? hi_latch : '1;
      default:   quick_data = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend   <= 1'b0;
      hi_valid  <= 1'b0;
      hi_tag    <= '0;
      pend_tag  <= '0;
      hi_latch  <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (rd_pend) begin
        rd_pend   <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_data  <= reg_rdata[HALF_W-1:0];
        hi_latch  <= reg_rdata[WORD_W-1:HALF_W];
        hi_tag    <= pend_tag;
        hi_valid  <= 1'b1;
      end else if (fire_rd) begin
        if (kind == K_DATA_LO) begin
          rd_pend  <= 1'b1;
          pend_tag <= addr;
        end else begin
          rsp_valid <= 1'b1;
          rsp_data  <= quick_data;
        end
      end
    end
  end

  // R9: a waiting response keeps its value
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
  // R5: one bus read per low-half read
  a_r5_single_rd: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> !reg_rd_en);
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
  import mpb_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int HALF_W = 16,
  parameter int PHY_W  = 5,
  parameter int REG_W  = 5,
  parameter logic [PHY_W-1:0] PAGE_PHY  = 5'h18,
  parameter logic [PHY_W-1:0] DATA_BASE = 5'h10,
  localparam int ADDR_W = PAGE_W + 3 + (REG_W - 1) + 2,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdio_valid,
  output logic              mdio_ready,
  input  logic              mdio_write,
  input  logic [PHY_W-1:0]  mdio_phy,
  input  logic [REG_W-1:0]  mdio_reg,
  input  logic [HALF_W-1:0] mdio_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [HALF_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  output logic              reg_wr_en,
  output logic              reg_rd_en,
  input  logic [WORD_W-1:0] reg_rdata
);
  kind_t             kind;
  logic [PAGE_W-1:0] page;
  logic              busy;
  logic              fire;

  assign mdio_ready = !busy;
  assign fire       = mdio_valid && mdio_ready;

  mpb_decode #(
    .PAGE_W(PAGE_W), .PHY_W(PHY_W), .REG_W(REG_W),
    .PAGE_PHY(PAGE_PHY), .DATA_BASE(DATA_BASE)
  ) u_decode (
    .phy(mdio_phy), .regn(mdio_reg), .page(page),
    .kind(kind), .addr(reg_addr)
  );

  mpb_write_stage #(.PAGE_W(PAGE_W), .HALF_W(HALF_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .fire_wr(fire && mdio_write),
    .kind(kind), .wdata(mdio_wdata), .page(page),
    .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata)
  );

  mpb_read_path #(.PAGE_W(PAGE_W), .HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .fire_rd(fire && !mdio_write),
    .kind(kind), .addr(reg_addr), .page(page), .reg_rdata(reg_rdata),
    .rsp_ready(rsp_ready), .reg_rd_en(reg_rd_en), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .busy(busy)
  );

  // R8: bus writes only come from the data window
  a_r8_wr_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> mdio_phy[PHY_W-1:3] == DATA_BASE[PHY_W-1:3]);
  // R3: a high-half write never reaches the bus
  a_r3_hi_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mdio_write && mdio_reg[0]) |-> !reg_wr_en);
  // R9: no new request while a bus read is in flight
  a_r9_block_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> !mdio_ready);
  // R2: word-aligned bus address on every access
  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en || reg_rd_en) |-> reg_addr[1:0] == 2'b00);
endmodule

// File: tb/test_mdio_page_bridge.sv
`timescale 1ns/1ps
module test_mdio_page_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdio_valid = 1'b0;
  logic        mdio_ready;
  logic        mdio_write = 1'b0;
  logic [4:0]  mdio_phy = '0;
  logic [4:0]  mdio_reg = '0;
  logic [15:0] mdio_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic [17:0] reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_wr_en;
  logic        reg_rd_en;
  logic [31:0] reg_rdata = '0;

  int errors = 0;
  int checks = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic [17:0] last_waddr = '0;
  logic [31:0] last_wdata = '0;
  logic [17:0] last_raddr = '0;

  always #2 clk = ~clk;

  mdio_page_bridge i_mdio_page_bridge (
    .clk(clk), .rst_n(rst_n), .mdio_valid(mdio_valid), .mdio_ready(mdio_ready),
    .mdio_write(mdio_write), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
    .mdio_wdata(mdio_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata)
  );

  function automatic logic [31:0] model_word(logic [17:0] a);
    return {~a[15:0], a[15:0] ^ 16'hC3A5};
  endfunction

  always @(posedge clk) begin
    if (reg_wr_en) begin
      wr_cnt     <= wr_cnt + 1;
      last_waddr <= reg_addr;
      last_wdata <= reg_wdata;
    end
    if (reg_rd_en) begin
      rd_cnt     <= rd_cnt + 1;
      last_raddr <= reg_addr;
      reg_rdata  <= model_word(reg_addr);
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic wr, logic [4:0] phy, logic [4:0] rg, logic [15:0] d);
    @(negedge clk);
    mdio_valid = 1'b1; mdio_write = wr; mdio_phy = phy; mdio_reg = rg; mdio_wdata = d;
    while (!mdio_ready) @(negedge clk);
    @(negedge clk);
    mdio_valid = 1'b0;
  endtask

  task automatic do_read(logic [4:0] phy, logic [4:0] rg, output logic [15:0] d);
    send(1'b0, phy, rg, 16'h0);
    for (int i = 0; i < 8 && !rsp_valid; i++) @(negedge clk);
    d = rsp_valid ? rsp_data : 16'hDEAD;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    check("R10 ready after reset", {31'b0, mdio_ready}, 32'd1);
    check("R10 no response after reset", {31'b0, rsp_valid}, 32'd0);
    do_read(5'h18, 5'h00, d);
    check("R10 page zero", {16'b0, d}, 32'h0);
    do_read(5'h10, 5'h01, d);
    check("R7 high read with empty latch", {16'b0, d}, 32'hFFFF);
  endtask

  task automatic t_page;
    logic [15:0] d;
    send(1'b1, 5'h18, 5'h00, 16'h01FF);
    do_read(5'h18, 5'h00, d);
    check("R1 page max", {16'b0, d}, 32'h01FF);
    send(1'b1, 5'h18, 5'h00, 16'hFE55);
    do_read(5'h18, 5'h00, d);
    check("R1 upper data bits dropped", {16'b0, d}, 32'h0055);
  endtask

  task automatic t_write_pair;
    int w0;
    w0 = wr_cnt;
    send(1'b1, 5'h13, 5'h0B, 16'hBEEF);
    check("R3 high half no bus write", wr_cnt, w0);
    send(1'b1, 5'h13, 5'h0A, 16'h1234);
    check("R4 one bus write", wr_cnt, w0 + 1);
    check("R4 word data", last_wdata, 32'hBEEF1234);
    check("R2 write address", {14'b0, last_waddr}, {14'b0, 9'h055, 3'b011, 4'h5, 2'b00});
    send(1'b1, 5'h13, 5'h0A, 16'h5678);
    check("R4 staged high reused", last_wdata, 32'hBEEF5678);
    check("R4 second write count", wr_cnt, w0 + 2);
  endtask

  task automatic t_read_pair;
    logic [15:0] d;
    logic [17:0] a;
    int r0;
    send(1'b1, 5'h18, 5'h00, 16'h01FF);
    a = {9'h1FF, 3'b111, 4'hF, 2'b00};
    r0 = rd_cnt;
    do_read(5'h17, 5'h1E, d);
    check("R5 one bus read", rd_cnt, r0 + 1);
    check("R2 read address", {14'b0, last_raddr}, {14'b0, a});
    check("R5 low half", {16'b0, d}, {16'b0, model_word(a) & 32'h0000FFFF});
    do_read(5'h17, 5'h1F, d);
    check("R6 high half latched", {16'b0, d}, {16'b0, model_word(a) >> 16});
    check("R6 no extra bus read", rd_cnt, r0 + 1);
    do_read(5'h17, 5'h03, d);
    check("R7 other address high read", {16'b0, d}, 32'hFFFF);
  endtask

  task automatic t_out_of_range;
    logic [15:0] d;
    int w0, r0;
    w0 = wr_cnt; r0 = rd_cnt;
    send(1'b1, 5'h05, 5'h00, 16'h0012);
    send(1'b1, 5'h19, 5'h00, 16'h00AA);
    send(1'b1, 5'h18, 5'h02, 16'h0033);
    check("R8 no bus write", wr_cnt, w0);
    do_read(5'h18, 5'h00, d);
    check("R8 page unchanged", {16'b0, d}, 32'h01FF);
    do_read(5'h19, 5'h04, d);
    check("R8 read outside window", {16'b0, d}, 32'hFFFF);
    do_read(5'h18, 5'h01, d);
    check("R8 other page-phy register", {16'b0, d}, 32'hFFFF);
    check("R8 no bus read", rd_cnt, r0);
  endtask

  task automatic t_backpressure;
    logic [15:0] d0;
    logic [17:0] a;
    a = {9'h1FF, 3'b000, 4'h2, 2'b00};
    rsp_ready = 1'b0;
    send(1'b0, 5'h10, 5'h04, 16'h0);
    for (int i = 0; i < 8 && !rsp_valid; i++) @(negedge clk);
    d0 = rsp_data;
    repeat (3) @(negedge clk);
    check("R9 response held", {31'b0, rsp_valid}, 32'd1);
    check("R9 data stable", {16'b0, rsp_data}, {16'b0, d0});
    check("R9 data value", {16'b0, d0}, {16'b0, model_word(a) & 32'h0000FFFF});
    check("R9 ready low while pending", {31'b0, mdio_ready}, 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R9 response taken", {31'b0, rsp_valid}, 32'd0);
    check("R9 ready restored", {31'b0, mdio_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_page;
    t_write_pair;
    t_read_pair;
    t_out_of_range;
    t_backpressure;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule